// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Locked-Sequence Hold

This block decides which of several bus initiators may drive the address phase of a shared AHB-style bus. Each initiator raises a request line and, if it needs an indivisible sequence, a lock line. The arbiter returns a registered one-hot grant vector, the index of the initiator that currently owns the address phase, and a flag telling downstream targets that the present address phase belongs to a locked sequence.

The grant register is re-evaluated on every clock. It can move while the bus is stalled, and it can land on an initiator that never asked for it, because initiators only act on it when the global ready is high. Ownership, meaning the index and the lock flag, advances only on ready-high edges. That keeps both values aligned with the address phase actually on the bus. The grant is frozen while the granted initiator holds both its request and its lock. It is also frozen while the bus shows that a locked burst still has beats to issue. When no initiator requests, the grant falls back to a default initiator.

Top module: `ahb_lock_arbiter`

## Requirements
- R1: During reset, and for two clock edges after reset is released, grant is one-hot on initiator 0 (value 0001), the owner index is 0 and the lock flag is 0. Asserting reset takes effect at once, without waiting for a clock edge.
- R2: With no hold in force, the grant on the following edge goes to the lowest-numbered requesting initiator, and the grant vector is always one-hot.
- R3: With no request and no hold in force, the grant on the following edge goes to initiator 0, which need not be requesting.
- R4: On an edge where ready is high, the owner index takes the index of the initiator granted just before that edge. On an edge where ready is low, the owner index keeps its value.
- R5: On an edge where ready is high, the lock flag takes the lock bit of the initiator granted just before that edge. On an edge where ready is low, the lock flag keeps its value.
- R6: While the granted initiator holds both its request and its lock bit, the grant does not change, even when a higher-priority initiator requests.
- R7: While the lock flag is 1, the grant does not change if the transfer type is SEQ (11) or BUSY (10 is NONSEQ, 01 is BUSY), or if it is NONSEQ with a burst type other than SINGLE (000). A locked NONSEQ SINGLE or an IDLE (00) transfer does not hold the grant.
- R8: When ready is low and no hold is in force, the grant still follows the requests on the next edge, which withdraws a grant mid-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_MASTERS | Per-initiator bus request |
| lock_i | input | N_MASTERS | Per-initiator locked-sequence request |
| trans_i | input | 2 | Transfer type of the current owner: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| burst_i | input | 3 | Burst type of the current owner, 000 is SINGLE |
| ready_i | input | 1 | Global transfer-ready |
| grant_o | output | N_MASTERS | One-hot registered grant |
| owner_o | output | IDX_W | Index of the address-phase owner |
| owner_lock_o | output | 1 | Current address phase is locked |

## Verification
The grant is due exactly one edge after the requests, lock bits and transfer type that decide it. The owner index and lock flag are due one edge after a ready-high cycle and reflect the grant that was in place before that edge. Every stimulus is therefore applied on a falling edge and compared on the next falling edge, after one rising edge, against a value worked out from the state one step back. The reset test applies a request during the release window and checks that the grant moves only on the third rising edge after release.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
  localparam logic [2:0] BU_SINGLE = 3'b000;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N_MASTERS      = 4,
  parameter int DEFAULT_MASTER = 0
) (
  input  logic [N_MASTERS-1:0] req_i,
  output logic [N_MASTERS-1:0] pick_o
);
  localparam logic [N_MASTERS-1:0] DEF_OH = N_MASTERS'(1) << DEFAULT_MASTER;

  logic [N_MASTERS-1:0] below;
  logic [N_MASTERS-1:0] first;
  logic                 any_req;

  genvar i;
  generate
    for (i = 0; i < N_MASTERS; i++) begin : g_chain
      if (i == 0) begin : g_head
        assign below[i] = 1'b0;
      end else begin : g_body
        assign below[i] = below[i-1] | req_i[i-1];
      end
      assign first[i] = req_i[i] & ~below[i];
    end
  endgenerate

  assign any_req = below[N_MASTERS-1] | req_i[N_MASTERS-1];

  always_comb begin
    if (any_req) pick_o = first;
    else         pick_o = DEF_OH;
  end
endmodule

// File: rtl/arb_hold_ctl.sv
module arb_hold_ctl #(
  parameter int N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] grant_q_i,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] lock_i,
  input  logic                 owner_lock_i,
  input  logic [1:0]           trans_i,
  input  logic [2:0]           burst_i,
  output logic                 hold_o
);
  import arb_pkg::*;

  logic grantee_locking;
  logic burst_continues;

  always_comb begin
    grantee_locking = |(grant_q_i & req_i & lock_i);
    burst_continues = (trans_i == TR_SEQ) || (trans_i == TR_BUSY) ||
                      ((trans_i == TR_NONSEQ) && (burst_i != BU_SINGLE));
    hold_o = grantee_locking | (owner_lock_i & burst_continues);
  end
endmodule

// File: rtl/arb_phase_regs.sv
module arb_phase_regs #(
  parameter int N_MASTERS      = 4,
  parameter int DEFAULT_MASTER = 0,
  localparam int IDX_W         = $clog2(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ready_i,
  input  logic [N_MASTERS-1:0] grant_q_i,
  input  logic [N_MASTERS-1:0] lock_i,
  output logic [IDX_W-1:0]     owner_o,
  output logic                 owner_lock_o
);
  logic [IDX_W-1:0] idx_nxt;
  logic             lock_nxt;
  logic             phase_en;

  always_comb begin
    idx_nxt = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (grant_q_i[i]) idx_nxt = idx_nxt | IDX_W'(i);
    end
    lock_nxt = |(grant_q_i & lock_i);
    phase_en = ready_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_o      <= IDX_W'(DEFAULT_MASTER);
      owner_lock_o <= 1'b0;
    end else if (phase_en) begin
      owner_o      <= idx_nxt;
      owner_lock_o <= lock_nxt;
    end
  end
endmodule

// File: rtl/ahb_lock_arbiter.sv
module ahb_lock_arbiter #(
  parameter int N_MASTERS      = 4,
  parameter int DEFAULT_MASTER = 0,
  localparam int IDX_W         = $clog2(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] lock_i,
  input  logic [1:0]           trans_i,
  input  logic [2:0]           burst_i,
  input  logic                 ready_i,
  output logic [N_MASTERS-1:0] grant_o,
  output logic [IDX_W-1:0]     owner_o,
  output logic                 owner_lock_o
);
  localparam logic [N_MASTERS-1:0] DEF_OH = N_MASTERS'(1) << DEFAULT_MASTER;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [N_MASTERS-1:0] grant_q;
  logic [N_MASTERS-1:0] pick;
  logic                 hold;
  logic                 grant_en;

  // reset asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  arb_prio_pick #(
    .N_MASTERS      (N_MASTERS),
    .DEFAULT_MASTER (DEFAULT_MASTER)
  ) u_pick (
    .req_i  (req_i),
    .pick_o (pick)
  );

  arb_hold_ctl #(
    .N_MASTERS (N_MASTERS)
  ) u_hold (
    .grant_q_i    (grant_q),
    .req_i        (req_i),
    .lock_i       (lock_i),
    .owner_lock_i (owner_lock_o),
    .trans_i      (trans_i),
    .burst_i      (burst_i),
    .hold_o       (hold)
  );

  assign grant_en = ~hold;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    grant_q <= DEF_OH;
    else if (grant_en) grant_q <= pick;
  end

  arb_phase_regs #(
    .N_MASTERS      (N_MASTERS),
    .DEFAULT_MASTER (DEFAULT_MASTER)
  ) u_phase (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .ready_i      (ready_i),
    .grant_q_i    (grant_q),
    .lock_i       (lock_i),
    .owner_o      (owner_o),
    .owner_lock_o (owner_lock_o)
  );

  assign grant_o = grant_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W    = $clog2(N_MASTERS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_i,
  input logic [N_MASTERS-1:0] lock_i,
  input logic                 ready_i,
  input logic [N_MASTERS-1:0] grant_o,
  input logic [IDX_W-1:0]     owner_o,
  input logic                 owner_lock_o
);
  logic [N_MASTERS-1:0] grant_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_d <= N_MASTERS'(1);
    else        grant_d <= grant_o;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) == 1); // R2
  AST_OWNER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> $stable(owner_o)); // R4
  AST_OWNER_FROM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ready_i |=> grant_d[owner_o]); // R4
  AST_LOCKFLAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> $stable(owner_lock_o)); // R5
  AST_LOCKED_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & req_i & lock_i) != '0) |=> $stable(grant_o)); // R6
  AST_IDLE_TO_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0 && !owner_lock_o) |=> grant_o[0]); // R3
endmodule

bind ahb_lock_arbiter arb_checker #(.N_MASTERS(N_MASTERS)) u_arb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .lock_i       (lock_i),
  .ready_i      (ready_i),
  .grant_o      (grant_o),
  .owner_o      (owner_o),
  .owner_lock_o (owner_lock_o)
);

// File: tb/ahb_lock_arbiter_bench.sv
module ahb_lock_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic       clk;
  logic       rst_n;
  logic [3:0] req_i;
  logic [3:0] lock_i;
  logic [1:0] trans_i;
  logic [2:0] burst_i;
  logic       ready_i;
  logic [3:0] grant_o;
  logic [1:0] owner_o;
  logic       owner_lock_o;

  int n_checks;
  int n_fails;
  bit finished;

  ahb_lock_arbiter u_ahb_lock_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .lock_i       (lock_i),
    .trans_i      (trans_i),
    .burst_i      (burst_i),
    .ready_i      (ready_i),
    .grant_o      (grant_o),
    .owner_o      (owner_o),
    .owner_lock_o (owner_lock_o)
  );

  // {req, lock, trans, burst, ready, exp grant, exp owner, exp lockflag, tag}
  localparam logic [24:0] VEC [0:NV-1] = '{
    {4'b0000, 4'b0000, 2'b00, 3'b000, 1'b1, 4'b0001, 2'd0, 1'b0, 4'd3}, // R3 idle stays default
    {4'b0100, 4'b0000, 2'b00, 3'b000, 1'b1, 4'b0100, 2'd0, 1'b0, 4'd2}, // R2 single requester
    {4'b0110, 4'b0000, 2'b00, 3'b000, 1'b1, 4'b0010, 2'd2, 1'b0, 4'd2}, // R2 lower index wins
    {4'b0110, 4'b0000, 2'b00, 3'b000, 1'b0, 4'b0010, 2'd2, 1'b0, 4'd4}, // R4 owner frozen
    {4'b0100, 4'b0000, 2'b00, 3'b000, 1'b0, 4'b0100, 2'd2, 1'b0, 4'd8}, // R8 grant moves while stalled
    {4'b0100, 4'b0100, 2'b00, 3'b000, 1'b1, 4'b0100, 2'd2, 1'b1, 4'd5}, // R5 lock flag sampled
    {4'b0101, 4'b0100, 2'b10, 3'b000, 1'b1, 4'b0100, 2'd2, 1'b1, 4'd6}, // R6 lock beats priority
    {4'b0101, 4'b0000, 2'b11, 3'b011, 1'b1, 4'b0100, 2'd2, 1'b0, 4'd7}, // R7 SEQ keeps grant
    {4'b0101, 4'b0000, 2'b11, 3'b011, 1'b1, 4'b0001, 2'd2, 1'b0, 4'd2}, // R2 unlocked, priority resumes
    {4'b0001, 4'b0001, 2'b00, 3'b000, 1'b0, 4'b0001, 2'd2, 1'b0, 4'd5}, // R5 lock flag frozen
    {4'b0001, 4'b0001, 2'b00, 3'b000, 1'b1, 4'b0001, 2'd0, 1'b1, 4'd5}, // R5 lock flag taken
    {4'b0010, 4'b0000, 2'b10, 3'b000, 1'b1, 4'b0010, 2'd0, 1'b0, 4'd7}, // R7 locked SINGLE no hold
    {4'b1000, 4'b1000, 2'b00, 3'b000, 1'b1, 4'b1000, 2'd1, 1'b0, 4'd2}, // R2 to top index
    {4'b1000, 4'b1000, 2'b10, 3'b001, 1'b1, 4'b1000, 2'd3, 1'b1, 4'd6}, // R6 locked hold
    {4'b0000, 4'b0000, 2'b01, 3'b001, 1'b0, 4'b1000, 2'd3, 1'b1, 4'd7}, // R7 BUSY keeps grant
    {4'b0000, 4'b0000, 2'b00, 3'b000, 1'b1, 4'b0001, 2'd3, 1'b0, 4'd3}, // R3 default w/o request
    {4'b0000, 4'b0000, 2'b00, 3'b000, 1'b1, 4'b0001, 2'd0, 1'b0, 4'd4}  // R4 owner follows
  };

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [3:0] rq, input logic [3:0] lk, input logic [1:0] tr,
                       input logic [2:0] bu, input logic rdy);
    req_i = rq; lock_i = lk; trans_i = tr; burst_i = bu; ready_i = rdy;
  endtask

  initial begin
    n_checks = 0; n_fails = 0; finished = 0;
    rst_n = 1'b0;
    drive(4'b0000, 4'b0000, 2'b00, 3'b000, 1'b1);
    repeat (3) @(negedge clk);
    check("R1 reset state", {25'd0, grant_o, owner_o, owner_lock_o}, {25'd0, 4'b0001, 2'd0, 1'b0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][24:21], VEC[i][20:17], VEC[i][16:15], VEC[i][14:12], VEC[i][11]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
            {25'd0, grant_o, owner_o, owner_lock_o}, {25'd0, VEC[i][10:4]});
    end

    // R2 priority sweep
    for (int k = 0; k < 4; k++) begin
      drive(4'b1111 << k, 4'b0000, 2'b00, 3'b000, 1'b1);
      @(negedge clk);
      check($sformatf("R2 sweep %0d", k), {28'd0, grant_o}, {28'd0, 4'b0001 << k});
    end

    // R1 asynchronous assertion mid-run
    drive(4'b1000, 4'b1000, 2'b00, 3'b000, 1'b1);
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1 async reset", {25'd0, grant_o, owner_o, owner_lock_o}, {25'd0, 4'b0001, 2'd0, 1'b0});
    @(negedge clk);
    drive(4'b0010, 4'b0000, 2'b00, 3'b000, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 release window", {28'd0, grant_o}, {28'd0, 4'b0001});
    @(negedge clk);
    check("R1 first grant after release", {28'd0, grant_o}, {28'd0, 4'b0010});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule